// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Buffer

This block sits between a 16-bit instruction fetch bus and the decoder of a byte-oriented instruction set whose instructions are one to four bytes long. Each accepted fetch deposits two bytes into a six-entry byte store, directly after the bytes already held. The decoder always sees the oldest unconsumed byte at the low end of a four-byte window, along with a count of how many window bytes are valid.

After decoding, the decoder reports how many bytes it used. The buffer discards exactly that many and slides the rest down to position zero. A fetch and a consume can occur in the same cycle, so fetch and decode can overlap. The block also keeps the fetch address, which advances by two per accepted word. A flush, for a branch or an interrupt, empties the store and reloads the address.

Top module: `ifetch_align_buf`

## Requirements
- R1: After reset the buffer holds no bytes, `win_count` is 0, `fetch_ready` is 1 and `fetch_addr` equals the `RESET_ADDR` parameter.
- R2: Bits [8k+7:8k] of `win` carry the k-th oldest unconsumed byte. Within a fetch word, bits [7:0] are the earlier byte and bits [15:8] the later one. `win_count` is the lesser of 4 and the number of bytes held.
- R3: `fetch_ready` is 1 exactly when `flush` is 0 and the held count, minus any legal consume in the same cycle, is at most 4. A word is accepted when `fetch_valid` and `fetch_ready` are both 1.
- R4: A legal consume drops the `consume_len` oldest bytes. A consume is legal when `consume_valid` is 1, `consume_len` is 1 to 4, and the length does not exceed the held count. The remaining bytes move so that the next one appears at window byte 0.
- R5: When a legal consume and an accepted fetch share a cycle, the new word follows the remaining bytes. The next count is the count minus the length plus 2.
- R6: An illegal consume, meaning a length of 0, a length of 5 to 7, or a length above the held count, drops no bytes and leaves the window unchanged.
- R7: A `flush` empties the buffer on the next edge and loads `fetch_addr` from `flush_addr`. It overrides a fetch or consume in the same cycle, and `fetch_ready` is 0 while `flush` is 1.
- R8: `fetch_addr` increases by 2 on every accepted fetch word and is otherwise unchanged, apart from reset and flush.
- R9: With 5 or 6 bytes held and no consume, `fetch_ready` is 0 and a fetch offered that cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty buffer and redirect fetch |
| flush_addr | input | ADDR_W | New fetch address on flush |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_data | input | 16 | Fetch word, earlier byte in [7:0] |
| fetch_ready | output | 1 | Buffer can take the offered word |
| fetch_addr | output | ADDR_W | Address of next word to fetch |
| consume_valid | input | 1 | Decoder consumes bytes this cycle |
| consume_len | input | 3 | Number of bytes consumed |
| win | output | 32 | Aligned instruction window, byte 0 in [7:0] |
| win_count | output | 3 | Valid bytes in the window, 0 to 4 |

## Verification
The hardest state to reach is the fetch-ready boundary where the buffer already holds five or six bytes and a consume and a fetch arrive in the same cycle. The ready decision then depends on the consume length presented in that very cycle. The bench reaches it by filling the buffer with back-to-back fetches while the decoder idles, then issuing consumes of every length with a fetch offered alongside. A long stretch of random fetch, consume and occasional flush traffic follows, and every consumed byte is compared against a byte-stream scoreboard.

// File: rtl/ifetch_align_buf.sv
module ifetch_align_buf #(
  parameter int ADDR_W      = 16,
  parameter int MAX_LEN     = 4,
  parameter int FETCH_BYTES = 2,
  parameter int LEN_W       = $clog2(MAX_LEN + 1),
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [ADDR_W-1:0]        flush_addr,
  input  logic                     fetch_valid,
  input  logic [FETCH_BYTES*8-1:0] fetch_data,
  output logic                     fetch_ready,
  output logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     consume_valid,
  input  logic [LEN_W-1:0]         consume_len,
  output logic [MAX_LEN*8-1:0]     win,
  output logic [LEN_W-1:0]         win_count
);
  localparam int DEPTH = MAX_LEN + FETCH_BYTES;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [7:0]       nxt [DEPTH];
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] drop, rem;
  logic             legal, push;

  assign legal = consume_valid && (consume_len != '0) &&
                 (int'(consume_len) <= MAX_LEN) && (int'(consume_len) <= int'(occ));
  assign drop  = legal ? CNT_W'(consume_len) : '0;
  assign rem   = occ - drop;
  assign fetch_ready = !flush && (int'(rem) <= MAX_LEN);
  assign push  = fetch_valid && fetch_ready;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = 8'h00;
      for (int j = 0; j < DEPTH; j++)
        if (j == i + int'(drop)) nxt[i] = mem[j];
      for (int k = 0; k < FETCH_BYTES; k++)
        if (push && i == int'(rem) + k) nxt[i] = fetch_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ        <= '0;
      fetch_addr <= RESET_ADDR;
    end else if (flush) begin
      occ        <= '0;
      fetch_addr <= flush_addr;
    end else begin
      occ <= rem + (push ? CNT_W'(FETCH_BYTES) : '0);
      if (push) fetch_addr <= fetch_addr + ADDR_W'(FETCH_BYTES);
    end
  end

  always_ff @(posedge clk)
    if (rst_n && !flush) mem <= nxt;

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_win
    assign win[8*k +: 8] = mem[k];
  end

  assign win_count = (int'(occ) > MAX_LEN) ? LEN_W'(MAX_LEN) : LEN_W'(occ);
endmodule

// File: rtl/ifetch_align_buf_chk.sv
module ifetch_align_buf_chk #(
  parameter int ADDR_W      = 16,
  parameter int MAX_LEN     = 4,
  parameter int FETCH_BYTES = 2,
  parameter int LEN_W       = $clog2(MAX_LEN + 1),
  parameter int CNT_W       = $clog2(MAX_LEN + FETCH_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [ADDR_W-1:0] flush_addr,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              consume_valid,
  input logic [LEN_W-1:0]  consume_len,
  input logic [CNT_W-1:0]  occ,
  input logic [LEN_W-1:0]  win_count
);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= MAX_LEN + FETCH_BYTES);

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0) && (fetch_addr == $past(flush_addr)));

  p_flush_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_ready);

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(fetch_valid && fetch_ready) && consume_valid &&
     int'(consume_len) > int'(occ)) |=> $stable(occ));

  p_consume_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !fetch_valid && consume_valid && consume_len != '0 &&
     int'(consume_len) <= MAX_LEN && int'(consume_len) <= int'(occ))
    |=> int'(occ) == int'($past(occ)) - int'($past(consume_len)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && fetch_valid && fetch_ready)
    |=> fetch_addr == $past(fetch_addr) + ADDR_W'(FETCH_BYTES));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume_valid && int'(occ) > MAX_LEN) |-> !fetch_ready);

  p_win_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_count) <= MAX_LEN);
endmodule

bind ifetch_align_buf ifetch_align_buf_chk #(
  .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .FETCH_BYTES(FETCH_BYTES), .LEN_W(LEN_W),
  .CNT_W($clog2(MAX_LEN + FETCH_BYTES + 1))
) u_chk (.*);

// File: tb/tb_ifetch_align_buf.sv
module tb_ifetch_align_buf;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_A = 16'h0100;

  logic        clk = 0, rst_n = 0, flush = 0, fetch_valid = 0, consume_valid = 0;
  logic [15:0] flush_addr = 0, fetch_data = 0, fetch_addr;
  logic [2:0]  consume_len = 0, win_count;
  logic        fetch_ready;
  logic [31:0] win;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  exp_q[$];
  logic [15:0] exp_addr;
  logic [7:0]  seed = 8'h10;

  ifetch_align_buf #(.RESET_ADDR(RST_A)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives one cycle; the monitor part compares window and ready against the scoreboard queue.
  task automatic cyc(input string tag, input bit fv, input bit cv, input int len,
                     input bit fl = 0, input logic [15:0] fa = 0);
    int n, lg;
    bit rdy;
    @(negedge clk);
    fetch_valid = fv; fetch_data = {seed + 8'd1, seed};
    consume_valid = cv; consume_len = 3'(len);
    flush = fl; flush_addr = fa;
    #1;
    lg  = (cv && len >= 1 && len <= 4 && len <= exp_q.size()) ? len : 0;
    rdy = !fl && (exp_q.size() - lg) <= 4;
    n   = exp_q.size() > 4 ? 4 : exp_q.size();
    chk({tag, " R3 ready"}, fetch_ready, rdy);
    chk({tag, " R2 count"}, win_count, n);
    for (int k = 0; k < n; k++) chk({tag, " R2 byte"}, win[8*k +: 8], exp_q[k]);
    chk({tag, " R8 addr"}, fetch_addr, exp_addr);
    if (fl) begin
      exp_q.delete();
      exp_addr = fa;
    end else begin
      for (int k = 0; k < lg; k++) void'(exp_q.pop_front());
      if (fv && rdy) begin
        exp_q.push_back(seed); exp_q.push_back(seed + 8'd1);
        seed += 8'd2;
        exp_addr += 16'd2;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_addr = RST_A;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 count", win_count, 0);
    chk("R1 ready", fetch_ready, 1);
    chk("R1 addr", fetch_addr, RST_A);
    // fill to 6, then a rejected fetch at full
    cyc("R5 fill", 1, 0, 0); cyc("R5 fill", 1, 0, 0); cyc("R5 fill", 1, 0, 0);
    cyc("R9 full", 1, 0, 0);
    chk("R9 held", exp_q.size(), 6);
    cyc("R9 after", 1, 1, 1);
    cyc("R4 len2", 1, 1, 2);
    cyc("R4 len3", 1, 1, 3);
    cyc("R4 len4", 1, 1, 4);
    cyc("R5 len2", 1, 1, 2);
    // illegal lengths
    cyc("R6 len0", 0, 1, 0); cyc("R6 chk", 0, 0, 0);
    cyc("R6 len5", 0, 1, 5); cyc("R6 chk", 0, 0, 0);
    cyc("R6 len7", 0, 1, 7); cyc("R6 chk", 0, 0, 0);
    while (exp_q.size() > 2) cyc("R4 drain", 0, 1, 1);
    cyc("R6 over", 0, 1, 3); cyc("R6 chk", 0, 0, 0);
    // flush overriding fetch and consume
    cyc("R7 flush", 1, 1, 1, 1, 16'h4000);
    cyc("R7 after", 0, 0, 0);
    chk("R7 empty", win_count, 0);
    cyc("R7 refill", 1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      cyc("R5 rand", $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 5),
          r < 3, 16'($urandom));
    end
    cyc("R2 end", 0, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule